// File: doc/BRIEF.md
# RISC Integer ALU

This block is the arithmetic and logic unit of a 32-bit three-operand register machine. It is purely combinational. Each evaluation takes two data operands, a shift count and an operation code from an outside instruction decoder, and returns a result word together with a flag that says whether that word is zero. The branch-on-equal logic uses the flag: it subtracts the two registers and tests it.

The operation set covers wrapping addition and subtraction, three bitwise functions (AND, OR, NOR), two magnitude comparisons and two logical shifts. The comparisons read the same bit patterns as signed or as unsigned numbers. The shifts move operand B by a separate 5-bit count. An upper-half constant placement moves the low half of operand B into the top half of the result. A complement needs no operation of its own, because NOR against a zero operand gives it. Operand sign extension, register access and overflow trapping belong to other blocks.

Top module: `rialu_top`

## Requirements
- R1: Operation code 0 (add) gives A + B modulo 2^32, with no overflow indication.
- R2: Operation code 1 (subtract) gives A - B modulo 2^32, with no overflow indication.
- R3: Operation code 2 gives the bitwise AND of A and B, and code 3 gives the bitwise OR.
- R4: Operation code 4 gives the bitwise inverse of (A OR B), so with B = 0 the result is the complement of A.
- R5: Operation code 5 gives 1 when A < B as two's-complement numbers and 0 otherwise, with bits 31:1 zero. A = 0xFFFFFFFF and B = 0x00000001 give 1.
- R6: Operation code 6 gives 1 when A < B as unsigned numbers and 0 otherwise, with bits 31:1 zero. A = 0xFFFFFFFF and B = 0x00000001 give 0.
- R7: Operation code 7 shifts B left by the 5-bit shift count and fills the freed low bits with zeros.
- R8: Operation code 8 shifts B right by the 5-bit shift count and fills the freed high bits with zeros.
- R9: Operation code 9 puts B[15:0] into result bits 31:16 and clears bits 15:0.
- R10: The zero flag is 1 exactly when the 32-bit result is zero, for every operation code.
- R11: Operation codes 10 to 15 give a result of zero, so the zero flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code from the decoder |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; the shift source and the constant source |
| shamt | input | 5 | Shift count for the two shift operations |
| result | output | 32 | Result word |
| zero | output | 1 | High when the result is all zeros |

## Verification
The zero flag and the result of the selected operation settle in the same evaluation, so each result check also checks the flag. Equal operands are subtracted to make a zero result, as a branch-equal test would. Comparisons that come out false also make a zero result, as do shifts that push every set bit out. In each case the bench expects a result of 0x00000000 and the flag high. Nonzero results from the same operations check that the flag then stays low.

// File: rtl/rialu_pkg.sv
// Package: operation codes and shared widths for the integer ALU.
// Assumes the external decoder drives these 4-bit codes directly.
package rialu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLTU = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_LUI  = 4'd9
    } alu_op_e;

    // Highest operation code in use; codes above it produce zero.
    localparam logic [OP_W-1:0] OP_LAST = 4'd9;
endpackage

// File: rtl/rialu_addsub.sv
// Module: shared adder/subtractor with signed and unsigned less-than outputs.
// Assumes the comparison outputs are only used while sub_en is high.
module rialu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    output logic [W-1:0] sum,
    output logic         lt_signed,
    output logic         lt_unsigned
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;
    logic         carry;
    logic         ovf;

    // Invert B and add one for subtraction.
    assign b_eff = sub_en ? ~b : b;
    assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
    assign sum   = full[W-1:0];
    assign carry = full[W];

    // Signed overflow of the internal addition, used only to order signed values.
    assign ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

    // Signed less-than: sign of the difference, corrected for overflow.
    assign lt_signed   = sum[W-1] ^ ovf;
    // Unsigned less-than: borrow out of the subtraction.
    assign lt_unsigned = ~carry;
endmodule

// File: rtl/rialu_logic.sv
// Module: bitwise unit producing AND, OR or NOR of the two operands.
// Assumes sel codes 0..2; code 3 yields zero.
module rialu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);
    // Select the bitwise function.
    always_comb begin
        unique case (sel)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/rialu_shift.sv
// Module: logarithmic logical shifter, left or right, zero fill.
// Assumes W is a power of two so SHW bits cover every shift distance.
module rialu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    input  logic           to_right,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stage [0:SHW];

    assign stage[0] = din;

    // One stage per shift-count bit, each moving by a power of two.
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 2 ** i;
        assign stage[i+1] = !amt[i] ? stage[i]
                          : (to_right ? (stage[i] >> STEP) : (stage[i] << STEP));
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/rialu_top.sv
// Module: 32-bit integer ALU top; picks one unit result by operation code
// and flags an all-zero result. Purely combinational; assumes the decoder
// holds op_sel stable while the result is consumed.
module rialu_top #(
    parameter  int WIDTH = 32,
    localparam int SHW   = $clog2(WIDTH)
) (
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    import rialu_pkg::*;

    localparam int HALF = WIDTH / 2;

    alu_op_e          op;
    logic             sub_en;
    logic [WIDTH-1:0] arith_y;
    logic             lt_s;
    logic             lt_u;
    logic [1:0]       logic_sel;
    logic [WIDTH-1:0] logic_y;
    logic             shift_right;
    logic [WIDTH-1:0] shift_y;
    logic [WIDTH-1:0] lui_y;

    assign op = alu_op_e'(op_sel);

    // Subtract for SUB and both comparisons.
    assign sub_en = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);

    rialu_addsub #(.W(WIDTH)) u_addsub (
        .a           (opnd_a),
        .b           (opnd_b),
        .sub_en      (sub_en),
        .sum         (arith_y),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    // Map the operation code onto the bitwise unit's local select.
    always_comb begin
        unique case (op)
            OP_AND:  logic_sel = 2'd0;
            OP_OR:   logic_sel = 2'd1;
            OP_NOR:  logic_sel = 2'd2;
            default: logic_sel = 2'd3;
        endcase
    end

    rialu_logic #(.W(WIDTH)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (logic_sel),
        .y   (logic_y)
    );

    assign shift_right = (op == OP_SRL);

    rialu_shift #(.W(WIDTH), .SHW(SHW)) u_shift (
        .din      (opnd_b),
        .amt      (shamt),
        .to_right (shift_right),
        .dout     (shift_y)
    );

    // Upper-half constant placement.
    assign lui_y = {opnd_b[HALF-1:0], {HALF{1'b0}}};

    // Final result selection; unused codes give zero.
    always_comb begin
        if (op_sel > OP_LAST) begin
            result = '0;
        end else begin
            unique case (op)
                OP_ADD, OP_SUB:          result = arith_y;
                OP_AND, OP_OR, OP_NOR:   result = logic_y;
                OP_SLT:                  result = {{(WIDTH-1){1'b0}}, lt_s};
                OP_SLTU:                 result = {{(WIDTH-1){1'b0}}, lt_u};
                OP_SLL, OP_SRL:          result = shift_y;
                OP_LUI:                  result = lui_y;
                default:                 result = '0;
            endcase
        end
    end

    assign zero = (result == '0);
endmodule

// File: rtl/rialu_checker.sv
// Module: property checker for the integer ALU, bound to rialu_top.
// Immediate assertions evaluated whenever the combinational inputs change.
module rialu_checker #(
    parameter int W = 32
) (
    input logic [3:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         zero
);
    import rialu_pkg::*;

    localparam int HALF = W / 2;

    // Check result properties per operation.
    always_comb begin
        if (op_sel == OP_ADD) begin
            a_r1_add_inverse: assert (result - opnd_b == opnd_a)
                else $error("add result does not invert");
        end
        if (op_sel == OP_SUB && opnd_a == opnd_b) begin
            a_r2_sub_equal_zero: assert (zero && result == '0)
                else $error("equal subtract not flagged zero");
        end
        if (op_sel == OP_NOR && opnd_b == '0) begin
            a_r4_nor_complement: assert (result == ~opnd_a)
                else $error("nor with zero is not complement");
        end
        if (op_sel == OP_SLT || op_sel == OP_SLTU) begin
            a_r5_r6_slt_upper_clear: assert (result[W-1:1] == '0)
                else $error("compare upper bits set");
        end
        if (op_sel == OP_LUI) begin
            a_r9_lui_placement: assert (result[HALF-1:0] == '0 && result[W-1:HALF] == opnd_b[HALF-1:0])
                else $error("upper placement wrong");
        end
        if (op_sel > OP_LAST) begin
            a_r11_unknown_zero: assert (result == '0 && zero)
                else $error("unknown code not zero");
        end
        if (zero) begin
            a_r10_zero_means_empty: assert ($countones(result) == 0)
                else $error("zero flag with set bits");
        end
    end
endmodule

bind rialu_top rialu_checker #(.W(WIDTH)) u_rialu_checker (
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result),
    .zero   (zero)
);

// File: tb/test_rialu_top.sv
// Bench: directed tests, one task per scenario, each checking its own results.
module test_rialu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] opnd_a = 32'd0;
    logic [31:0] opnd_b = 32'd0;
    logic [4:0]  shamt = 5'd0;
    logic [31:0] result;
    logic        zero;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    rialu_top i_rialu_top (
        .op_sel (op_sel),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .shamt  (shamt),
        .result (result),
        .zero   (zero)
    );

    // Drive on the rising edge, sample on the falling edge.
    task automatic apply(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] sh);
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s result got %h expected %h", req, result, exp);
        end
        checks++;
        if (zero !== (exp == 32'd0)) begin
            errors++;
            $display("FAIL %s zero got %b expected %b", req, zero, exp == 32'd0);
        end
    endtask

    task automatic t_reset;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        apply(4'd0, 32'd0, 32'd0, 5'd0);
        check("R10 reset idle", 32'd0);
    endtask

    task automatic t_add;
        apply(4'd0, 32'd5, 32'd7, 5'd3);
        check("R1 add", 32'd12);
        apply(4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);
        check("R1 add wrap", 32'd0);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] a = $urandom, b = $urandom;
            apply(4'd0, a, b, 5'd0);
            check("R1 add sweep", a + b);
        end
    endtask

    task automatic t_sub;
        apply(4'd1, 32'd3, 32'd5, 5'd0);
        check("R2 sub wrap", 32'hFFFF_FFFE);
        apply(4'd1, 32'h1234_5678, 32'h1234_5678, 5'd0);
        check("R2 R10 sub equal", 32'd0);
        apply(4'd1, 32'h8000_0000, 32'd1, 5'd0);
        check("R2 sub min", 32'h7FFF_FFFF);
    endtask

    task automatic t_logic;
        apply(4'd2, 32'h0000_3C00, 32'h0000_0DC0, 5'd0);
        check("R3 and", 32'h0000_0C00);
        apply(4'd3, 32'h0000_3C00, 32'h0000_0DC0, 5'd0);
        check("R3 or", 32'h0000_3DC0);
        apply(4'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 5'd0);
        check("R3 R10 and disjoint", 32'd0);
    endtask

    task automatic t_nor;
        apply(4'd4, 32'h0000_3C00, 32'd0, 5'd0);
        check("R4 nor not", 32'hFFFF_C3FF);
        apply(4'd4, 32'hF0F0_0000, 32'h0000_F0F0, 5'd0);
        check("R4 nor", 32'h0F0F_0F0F);
        apply(4'd4, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0);
        check("R4 R10 nor all ones", 32'd0);
    endtask

    task automatic t_slt;
        apply(4'd5, 32'hFFFF_FFFF, 32'd1, 5'd0);
        check("R5 slt neg", 32'd1);
        apply(4'd5, 32'd1, 32'hFFFF_FFFF, 5'd0);
        check("R5 slt pos", 32'd0);
        apply(4'd5, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
        check("R5 slt extremes", 32'd0);
        apply(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
        check("R5 slt extremes rev", 32'd1);
        apply(4'd5, 32'd9, 32'd9, 5'd0);
        check("R5 slt equal", 32'd0);
    endtask

    task automatic t_sltu;
        apply(4'd6, 32'hFFFF_FFFF, 32'd1, 5'd0);
        check("R6 sltu big", 32'd0);
        apply(4'd6, 32'd1, 32'hFFFF_FFFF, 5'd0);
        check("R6 sltu small", 32'd1);
        apply(4'd6, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
        check("R6 sltu mid", 32'd1);
        for (int i = 0; i < 6; i++) begin
            logic [31:0] a = $urandom, b = $urandom;
            apply(4'd6, a, b, 5'd0);
            check("R6 sltu sweep", {31'd0, a < b});
            apply(4'd5, a, b, 5'd0);
            check("R5 slt sweep", {31'd0, $signed(a) < $signed(b)});
        end
    endtask

    task automatic t_shift;
        apply(4'd7, 32'hDEAD_BEEF, 32'h0000_0001, 5'd31);
        check("R7 sll max", 32'h8000_0000);
        apply(4'd7, 32'd0, 32'h8000_0001, 5'd1);
        check("R7 sll drop", 32'h0000_0002);
        apply(4'd7, 32'd0, 32'h1234_5678, 5'd0);
        check("R7 sll none", 32'h1234_5678);
        apply(4'd8, 32'd0, 32'h8000_0000, 5'd31);
        check("R8 srl max", 32'h0000_0001);
        apply(4'd8, 32'd0, 32'hF000_000F, 5'd4);
        check("R8 srl zero fill", 32'h0F00_0000);
        apply(4'd8, 32'd0, 32'h0000_00FF, 5'd8);
        check("R8 R10 srl out", 32'd0);
        for (int s = 0; s < 32; s += 5) begin
            logic [31:0] b = $urandom;
            apply(4'd7, 32'd0, b, 5'(s));
            check("R7 sll sweep", b << s);
            apply(4'd8, 32'd0, b, 5'(s));
            check("R8 srl sweep", b >> s);
        end
    endtask

    task automatic t_lui;
        apply(4'd9, 32'hFFFF_FFFF, 32'hABCD_AAAA, 5'd7);
        check("R9 lui", 32'hAAAA_0000);
        apply(4'd9, 32'd0, 32'hFFFF_0000, 5'd0);
        check("R9 R10 lui zero half", 32'd0);
    endtask

    task automatic t_unknown;
        for (int op = 10; op < 16; op++) begin
            apply(4'(op), 32'hFFFF_FFFF, 32'h1234_5678, 5'd3);
            check("R11 unknown code", 32'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_nor();
        t_slt();
        t_sltu();
        t_shift();
        t_lui();
        t_unknown();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule